// File: doc/BRIEF.md
# Command Stream Parser for a Graphics Register File

This block consumes a stream of 32-bit words arriving one per cycle and splits it into commands of varying length. The top byte of the first word of every command is the opcode. The parser applies register writes to an internal bank of 64 32-bit registers, either a 16-bit half or a whole word. It loads a small table of block pointers keyed by a 24-bit selector. It collects the words of a transform, which is a 3x3 matrix plus an offset vector. It also raises one-cycle strobes for render and sync commands.

The transform command has two lengths. It takes 8 words, or 13 words when the low half of its header holds the tag 0x7FFF. A word that arrives as the payload of a multi-word command is never decoded as an opcode. An opcode the parser does not know is consumed as a single word, and the next word is treated as a new header. The upstream side uses a valid/ready handshake, and ready drops while the downstream consumer reports busy.

Top module: `cmd_stream_parser`

## Requirements
- R1: After reset all 64 registers and all pointer entries read zero, every strobe output is low, and `in_ready` is high while `dn_busy` is low.
- R2: Opcode 0x17 is one word. Bits 22:16 give an index. An odd index writes bits 15:0 of the word into the upper half of register index/2 and leaves its lower half unchanged.
- R3: An even index in opcode 0x17 writes bits 15:0 into the lower half of register index/2 and leaves its upper half unchanged.
- R4: Opcode 0x18 is two words. The index in bits 22:16 of the first word selects register index/2, and the second word is written to that register whole.
- R5: Opcode 0x00 is two words. Bits 23:0 of the first word are a selector. If the selector matches a table key, the entry stores bits 29:24 of the second word as its length code (0 to 63, meaning 1 to 64 blocks) and bits 23:0 as its address. The default keys 0x008000, 0x00C040, 0x004040 and 0x00C0A5 occupy entries 0 to 3.
- R6: An opcode 0x00 whose selector matches no key raises `ptr_miss` for exactly the one cycle after its second word and leaves every table entry unchanged.
- R7: Opcode 0x13 raises `render_stb`, and opcode 0x1A raises `sync_stb`. Each is a single-word command, and its strobe is high for exactly the cycle after the word is accepted.
- R8: Opcode 0x1C with any low half other than 0x7FFF collects 8 words. `xform_valid` pulses for one cycle after the eighth word, with `xform_ext` low. Word k (the header is k=0) appears at bits 32k+31:32k of `xform_words`.
- R9: Opcode 0x1C with low half 0x7FFF collects 13 words. `xform_valid` stays low after the eighth word and pulses after the thirteenth, with `xform_ext` high.
- R10: Any other opcode consumes exactly one word, and the next word is decoded as a header.
- R11: While `dn_busy` is high, `in_ready` is low and a presented word is neither consumed nor acted upon. The word is taken once, on the first edge after `dn_busy` falls.
- R12: Payload words of multi-word commands are never decoded as opcodes, whatever their top byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream word present |
| in_ready | output | 1 | Parser takes the word this edge |
| in_data | input | 32 | Stream word |
| dn_busy | input | 1 | Downstream busy; holds off the stream |
| rd_addr | input | 6 | Register read index |
| rd_data | output | 32 | Register read value |
| ptr_rd_idx | input | 2 | Pointer table read entry |
| ptr_rd_len | output | 6 | Length code of the read entry |
| ptr_rd_addr | output | 24 | Block address of the read entry |
| ptr_miss | output | 1 | Pointer selector matched no key |
| render_stb | output | 1 | Render command seen |
| sync_stb | output | 1 | Sync command seen |
| xform_valid | output | 1 | Transform words complete |
| xform_ext | output | 1 | Completed transform is the 13-word form |
| xform_words | output | 416 | Collected transform words, header at bits 31:0 |

## Verification
The bench writes both halves of one register in turn. A parser that chose the half by the wrong index bit, or that cleared the other half, would show a wrong merged value. It sends payload words whose top byte equals the render opcode, and a parser that resynchronised early would pulse `render_stb`. It also probes the pointer table with an unknown selector after real loads, and a table that stored into any entry on a miss would show a changed entry. Both transform lengths are checked at the eighth word, where a parser that ignored the 0x7FFF tag would finish early. A word held through a busy window must produce exactly one render pulse, so a parser that ignored ready would fire during the stall.

// File: rtl/cmdp_pkg.sv
`timescale 1ns/1ps
package cmdp_pkg;
    localparam int WORD_W     = 32;
    localparam int SEL_W      = 24;
    localparam int LEN_W      = 6;
    localparam int BADDR_W    = 24;
    localparam int IDX_W      = 7;
    localparam int XFORM_MAX  = 13;
    localparam int XFORM_SHORT = 8;
    localparam int XCNT_W     = $clog2(XFORM_MAX);

    localparam logic [7:0]  OP_PTR    = 8'h00;
    localparam logic [7:0]  OP_RENDER = 8'h13;
    localparam logic [7:0]  OP_WR16   = 8'h17;
    localparam logic [7:0]  OP_WR32   = 8'h18;
    localparam logic [7:0]  OP_SYNC   = 8'h1A;
    localparam logic [7:0]  OP_XFORM  = 8'h1C;
    localparam logic [15:0] XFORM_EXT_TAG = 16'h7FFF;

    typedef enum logic [1:0] {
        ST_HDR   = 2'd0,
        ST_WR32  = 2'd1,
        ST_PTR   = 2'd2,
        ST_XFORM = 2'd3
    } pstate_e;

    typedef struct packed {
        pstate_e                            st;
        logic [IDX_W-1:0]                   reg_idx;
        logic [SEL_W-1:0]                   sel;
        logic [XCNT_W-1:0]                  widx;
        logic [XCNT_W-1:0]                  last;
        logic                               ext;
        logic [XFORM_MAX-1:0][WORD_W-1:0]   xw;
        logic                               render;
        logic                               sync;
        logic                               xvalid;
        logic                               miss;
    } parser_t;
endpackage

// File: rtl/cmdp_regfile.sv
`timescale 1ns/1ps
module cmdp_regfile #(
    parameter  int REG_COUNT = 64,
    parameter  int DATA_W    = 32,
    localparam int AW        = $clog2(REG_COUNT),
    localparam int HALF_W    = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_d [REG_COUNT];
    logic [DATA_W-1:0] mem_q [REG_COUNT];

    always_comb begin
        mem_d = mem_q;
        if (we_lo) mem_d[wr_addr][HALF_W-1:0]      = wr_data[HALF_W-1:0];
        if (we_hi) mem_d[wr_addr][DATA_W-1:HALF_W] = wr_data[DATA_W-1:HALF_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '{default: '0};
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_addr];

    assert_lo_half_written_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we_lo |=> mem_q[$past(wr_addr)][HALF_W-1:0] == $past(wr_data[HALF_W-1:0]));

    assert_hi_half_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_hi |=> mem_q[$past(wr_addr)][DATA_W-1:HALF_W] == $past(wr_data[DATA_W-1:HALF_W]));

    assert_lo_half_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_hi && !we_lo) |=> mem_q[$past(wr_addr)][HALF_W-1:0] == $past(mem_q[wr_addr][HALF_W-1:0]));
endmodule

// File: rtl/cmdp_ptr_table.sv
`timescale 1ns/1ps
module cmdp_ptr_table #(
    parameter  int ENTRIES = 4,
    parameter  int SEL_W   = 24,
    parameter  int LEN_W   = 6,
    parameter  int ADDR_W  = 24,
    parameter  logic [ENTRIES*SEL_W-1:0] KEYS = '0,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              hit,
    input  logic [IW-1:0]     rd_idx,
    output logic [LEN_W-1:0]  rd_len,
    output logic [ADDR_W-1:0] rd_addr
);
    logic [ENTRIES-1:0]              match;
    logic [ENTRIES-1:0][LEN_W-1:0]   len_d,  len_q;
    logic [ENTRIES-1:0][ADDR_W-1:0]  addr_d, addr_q;
    logic [IW-1:0]                   hit_idx;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_key
        assign match[e] = (wr_sel == KEYS[e*SEL_W +: SEL_W]);
    end

    assign hit = |match;

    always_comb begin
        len_d   = len_q;
        addr_d  = addr_q;
        hit_idx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (match[e]) hit_idx = IW'(e);
            if (wr_en && match[e]) begin
                len_d[e]  = wr_len;
                addr_d[e] = wr_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            addr_q <= '0;
        end else begin
            len_q  <= len_d;
            addr_q <= addr_d;
        end
    end

    assign rd_len  = len_q[rd_idx];
    assign rd_addr = addr_q[rd_idx];

    assert_ptr_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit) |=> (len_q[$past(hit_idx)] == $past(wr_len))
                         && (addr_q[$past(hit_idx)] == $past(wr_addr)));

    assert_miss_leaves_table_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> ($stable(len_q) && $stable(addr_q)));
endmodule

// File: rtl/cmd_stream_parser.sv
`timescale 1ns/1ps
module cmd_stream_parser
    import cmdp_pkg::*;
#(
    parameter  int REG_COUNT   = 64,
    parameter  int PTR_ENTRIES = 4,
    parameter  logic [PTR_ENTRIES*SEL_W-1:0] PTR_KEYS =
        {24'h00C0A5, 24'h004040, 24'h00C040, 24'h008000},
    localparam int REG_AW = $clog2(REG_COUNT),
    localparam int PTR_AW = $clog2(PTR_ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [WORD_W-1:0]           in_data,
    input  logic                        dn_busy,
    input  logic [REG_AW-1:0]           rd_addr,
    output logic [WORD_W-1:0]           rd_data,
    input  logic [PTR_AW-1:0]           ptr_rd_idx,
    output logic [LEN_W-1:0]            ptr_rd_len,
    output logic [BADDR_W-1:0]          ptr_rd_addr,
    output logic                        ptr_miss,
    output logic                        render_stb,
    output logic                        sync_stb,
    output logic                        xform_valid,
    output logic                        xform_ext,
    output logic [XFORM_MAX*WORD_W-1:0] xform_words
);
    parser_t cur_q, nxt_d;

    logic              accept;
    logic              we_lo, we_hi;
    logic [REG_AW-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;
    logic              ptr_we, ptr_hit;
    logic [IDX_W-1:0]  hdr_idx;
    logic [7:0]        hdr_op;

    assign in_ready = !dn_busy;
    assign accept   = in_valid && in_ready;
    assign hdr_op   = in_data[31:24];
    assign hdr_idx  = in_data[22:16];

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.render = 1'b0;
        nxt_d.sync   = 1'b0;
        nxt_d.xvalid = 1'b0;
        nxt_d.miss   = 1'b0;
        we_lo   = 1'b0;
        we_hi   = 1'b0;
        wr_addr = '0;
        wr_data = in_data;
        ptr_we  = 1'b0;
        if (accept) begin
            unique case (cur_q.st)
                ST_HDR: begin
                    case (hdr_op)
                        OP_WR16: begin
                            wr_addr = REG_AW'(hdr_idx >> 1);
                            wr_data = {in_data[15:0], in_data[15:0]};
                            we_hi   = hdr_idx[0];
                            we_lo   = !hdr_idx[0];
                        end
                        OP_WR32: begin
                            nxt_d.st      = ST_WR32;
                            nxt_d.reg_idx = hdr_idx;
                        end
                        OP_PTR: begin
                            nxt_d.st  = ST_PTR;
                            nxt_d.sel = in_data[SEL_W-1:0];
                        end
                        OP_RENDER: nxt_d.render = 1'b1;
                        OP_SYNC:   nxt_d.sync   = 1'b1;
                        OP_XFORM: begin
                            nxt_d.st    = ST_XFORM;
                            nxt_d.xw[0] = in_data;
                            nxt_d.widx  = XCNT_W'(1);
                            nxt_d.ext   = (in_data[15:0] == XFORM_EXT_TAG);
                            nxt_d.last  = (in_data[15:0] == XFORM_EXT_TAG)
                                        ? XCNT_W'(XFORM_MAX - 1)
                                        : XCNT_W'(XFORM_SHORT - 1);
                        end
                        default: ;
                    endcase
                end
                ST_WR32: begin
                    wr_addr  = REG_AW'(cur_q.reg_idx >> 1);
                    we_lo    = 1'b1;
                    we_hi    = 1'b1;
                    nxt_d.st = ST_HDR;
                end
                ST_PTR: begin
                    ptr_we     = 1'b1;
                    nxt_d.miss = !ptr_hit;
                    nxt_d.st   = ST_HDR;
                end
                ST_XFORM: begin
                    if (cur_q.widx < XCNT_W'(XFORM_MAX)) nxt_d.xw[cur_q.widx] = in_data;
                    if (cur_q.widx == cur_q.last) begin
                        nxt_d.xvalid = 1'b1;
                        nxt_d.st     = ST_HDR;
                    end else begin
                        nxt_d.widx = cur_q.widx + XCNT_W'(1);
                    end
                end
                default: nxt_d.st = ST_HDR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    cmdp_regfile #(
        .REG_COUNT (REG_COUNT),
        .DATA_W    (WORD_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_lo   (we_lo),
        .we_hi   (we_hi),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    cmdp_ptr_table #(
        .ENTRIES (PTR_ENTRIES),
        .SEL_W   (SEL_W),
        .LEN_W   (LEN_W),
        .ADDR_W  (BADDR_W),
        .KEYS    (PTR_KEYS)
    ) i_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ptr_we),
        .wr_sel  (cur_q.sel),
        .wr_len  (in_data[BADDR_W+LEN_W-1:BADDR_W]),
        .wr_addr (in_data[BADDR_W-1:0]),
        .hit     (ptr_hit),
        .rd_idx  (ptr_rd_idx),
        .rd_len  (ptr_rd_len),
        .rd_addr (ptr_rd_addr)
    );

    assign ptr_miss    = cur_q.miss;
    assign render_stb  = cur_q.render;
    assign sync_stb    = cur_q.sync;
    assign xform_valid = cur_q.xvalid;
    assign xform_ext   = cur_q.ext;
    assign xform_words = cur_q.xw;

    assert_one_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({render_stb, sync_stb, xform_valid, ptr_miss}));

    assert_stall_holds_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> ($stable(cur_q.st) && $stable(cur_q.widx)
                                     && !render_stb && !sync_stb));

    assert_xform_after_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xform_valid |-> $past(in_valid && in_ready && cur_q.st == ST_XFORM));

    assert_render_from_header_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (render_stb || sync_stb) |-> $past(cur_q.st) == ST_HDR);
endmodule

// File: tb/test_cmd_stream_parser.sv
`timescale 1ns/1ps
module test_cmd_stream_parser;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_data = '0;
    logic         dn_busy = 1'b0;
    logic [5:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic [1:0]   ptr_rd_idx = '0;
    logic [5:0]   ptr_rd_len;
    logic [23:0]  ptr_rd_addr;
    logic         ptr_miss, render_stb, sync_stb, xform_valid, xform_ext;
    logic [415:0] xform_words;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cmd_stream_parser i_cmd_stream_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .dn_busy(dn_busy), .rd_addr(rd_addr), .rd_data(rd_data),
        .ptr_rd_idx(ptr_rd_idx), .ptr_rd_len(ptr_rd_len), .ptr_rd_addr(ptr_rd_addr),
        .ptr_miss(ptr_miss), .render_stb(render_stb), .sync_stb(sync_stb),
        .xform_valid(xform_valid), .xform_ext(xform_ext), .xform_words(xform_words)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(posedge clk);
        while (!in_ready) @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = '0;
    endtask

    task automatic read_reg(input logic [5:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic read_ptr(input logic [1:0] e, output logic [5:0] l, output logic [23:0] a);
        ptr_rd_idx = e;
        #1;
        l = ptr_rd_len;
        a = ptr_rd_addr;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        logic [5:0]  l;
        logic [23:0] a;
        check("R1 ready", in_ready, 1);
        check("R1 strobes", {render_stb, sync_stb, xform_valid, ptr_miss}, 0);
        read_reg(6'd0, v);  check("R1 reg0", v, 0);
        read_reg(6'd63, v); check("R1 reg63", v, 0);
        read_ptr(2'd3, l, a); check("R1 ptr3", {l, a}, 0);
    endtask

    task automatic t_wr16;
        logic [31:0] v;
        send_word(32'h1703ABCD);
        read_reg(6'd1, v); check("R2 odd upper", v, 32'hABCD0000);
        send_word(32'h17021234);
        read_reg(6'd1, v); check("R3 even lower", v, 32'hABCD1234);
        send_word(32'h1702EEEE);
        read_reg(6'd1, v); check("R3 upper kept", v, 32'hABCDEEEE);
        send_word(32'h177FBEEF);
        read_reg(6'd63, v); check("R2 top index", v, 32'hBEEF0000);
        read_reg(6'd0, v);  check("R2 neighbour untouched", v, 0);
    endtask

    task automatic t_wr32;
        logic [31:0] v;
        send_word(32'h18100000);
        send_word(32'h13000000);
        check("R12 payload not rendered", render_stb, 0);
        read_reg(6'd8, v); check("R4 full write", v, 32'h13000000);
        send_word(32'h18110000);
        send_word(32'h1702_5A5A);
        read_reg(6'd8, v); check("R4 odd index same reg", v, 32'h17025A5A);
        read_reg(6'd1, v); check("R12 payload not a wr16", v, 32'hABCDEEEE);
    endtask

    task automatic t_ptr;
        logic [5:0]  l;
        logic [23:0] a;
        send_word(32'h0000C040);
        send_word(32'h15ABCDEF);
        check("R5 no miss", ptr_miss, 0);
        read_ptr(2'd1, l, a); check("R5 entry1", {l, a}, {6'h15, 24'hABCDEF});
        send_word(32'h00008000);
        send_word(32'hFF000010);
        read_ptr(2'd0, l, a); check("R5 entry0 len 63", {l, a}, {6'h3F, 24'h000010});
    endtask

    task automatic t_miss;
        logic [5:0]  l;
        logic [23:0] a;
        send_word(32'h00123456);
        send_word(32'h3FFFFFFF);
        check("R6 miss pulse", ptr_miss, 1);
        read_ptr(2'd0, l, a); check("R6 entry0 kept", {l, a}, {6'h3F, 24'h000010});
        read_ptr(2'd1, l, a); check("R6 entry1 kept", {l, a}, {6'h15, 24'hABCDEF});
        read_ptr(2'd2, l, a); check("R6 entry2 kept", {l, a}, 0);
        read_ptr(2'd3, l, a); check("R6 entry3 kept", {l, a}, 0);
        @(negedge clk);
        check("R6 miss one cycle", ptr_miss, 0);
    endtask

    task automatic t_strobes;
        send_word(32'h13000000);
        check("R7 render", {render_stb, sync_stb}, 2'b10);
        @(negedge clk);
        check("R7 render one cycle", render_stb, 0);
        send_word(32'h1A000000);
        check("R7 sync", {render_stb, sync_stb}, 2'b01);
        @(negedge clk);
        check("R7 sync one cycle", sync_stb, 0);
    endtask

    task automatic t_xform_short;
        send_word(32'h1C000011);
        for (int i = 1; i < 7; i++) send_word(32'h13000100 + i);
        check("R12 xform payload not rendered", render_stb, 0);
        check("R8 not yet valid", xform_valid, 0);
        send_word(32'h13000107);
        check("R8 valid", xform_valid, 1);
        check("R8 short form", xform_ext, 0);
        check("R8 word0", xform_words[31:0], 32'h1C000011);
        check("R8 word7", xform_words[7*32 +: 32], 32'h13000107);
        @(negedge clk);
        check("R8 valid one cycle", xform_valid, 0);
    endtask

    task automatic t_xform_long;
        send_word(32'h1C007FFF);
        for (int i = 1; i < 8; i++) send_word(32'h20000000 + i);
        check("R9 not done after 8", xform_valid, 0);
        for (int i = 8; i < 12; i++) send_word(32'h20000000 + i);
        check("R9 not done after 12", xform_valid, 0);
        send_word(32'h2000000C);
        check("R9 valid after 13", xform_valid, 1);
        check("R9 ext form", xform_ext, 1);
        check("R9 word12", xform_words[12*32 +: 32], 32'h2000000C);
        check("R9 word8", xform_words[8*32 +: 32], 32'h20000008);
    endtask

    task automatic t_unknown;
        logic [31:0] v;
        send_word(32'h55171234);
        send_word(32'h13000000);
        check("R10 next word is header", render_stb, 1);
        send_word(32'h99000000);
        send_word(32'h17057777);
        read_reg(6'd2, v); check("R10 wr16 after unknown", v, 32'h77770000);
    endtask

    task automatic t_stall;
        @(negedge clk);
        dn_busy  = 1'b1;
        in_valid = 1'b1;
        in_data  = 32'h13000000;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R11 ready low", in_ready, 0);
            check("R11 no render while busy", render_stb, 0);
        end
        dn_busy = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 taken after busy", render_stb, 1);
        @(negedge clk);
        check("R11 taken once", render_stb, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wr16();
        t_wr32();
        t_ptr();
        t_miss();
        t_strobes();
        t_xform_short();
        t_xform_long();
        t_unknown();
        t_stall();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule